// File: doc/BRIEF.md
# Prescaled Pulse-Width Modulator with Register Bank

This block produces one or two independent pulse-width modulated outputs. Each channel divides the input clock through a 6-bit prescaler. That prescaler steps a 10-bit period counter, and the output is high while the counter is below the programmed duty count. A separate flag forces the output permanently high. Software programs each channel through three word-addressed registers on a simple synchronous bus: a write strobe, an address, write data, and combinational read data.

A per-channel enable input starts and stops the waveform. The first period begins on the clock after the enable is seen high. When the enable falls, a mode bit in the control register picks one of two stops. In abrupt mode the output drops on the next clock. In graceful mode the current period finishes first. Register writes land in a live copy. The channel takes a working copy of all timing values only when it starts or crosses a period boundary, so no period is ever cut short or stretched.

Top module: `pwm_ctrl_top`

## Requirements
- R1: With the channel running, the output waveform repeats every (P+1)*(V+1) input clocks, where P is the prescale field and V is the period field.
- R2: With the full flag clear, the output is high for the first (P+1)*D clocks of each period, where D is the duty count. D = 0 gives a constantly low output, and any D above V+1 gives a constantly high output.
- R3: When the full flag (bit 10 of the duty register) is set, a running output stays high for the whole period, whatever D holds.
- R4: Within a channel, the control register sits at byte offset 0x00 (prescale in bits 5:0, stop-mode bit 6), the duty register at 0x04 (D in bits 9:0, full flag in bit 10) and the period register at 0x08 (V in bits 9:0). The second channel repeats this layout at 0x10, and offset 0x0C of each channel reads zero.
- R5: With the stop-mode bit set to 1, a low enable forces the output low from the very next clock.
- R6: With the stop-mode bit at 0, a low enable lets the current period run to its end. The output then stays low from the first clock of what would have been the next period.
- R7: Prescale, duty and period values written while a channel runs take effect only from the next period boundary.
- R8: Reading a register returns the value last written to it, with all bits outside its fields reading zero.
- R9: Reset, while held, clears every register and forces every output low.
- R10: When the block is built with one channel, writes to 0x10..0x1C change nothing, and reads there return zero.
- R11: Two channels run together without disturbing each other, each following its own registers and enable.
- R12: A running channel starts its first period, with its output high if D > 0 or the full flag is set, on the clock after its enable is sampled high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all logic and the PWM time base |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | AW (5) | Byte address of the register access |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Read data for bus_addr, combinational |
| chan_en | input | NUM_CH | Per-channel run enable |
| pwm_out | output | NUM_CH | Per-channel PWM output |

## Verification
A corrupted prescale or period counter shows at the pin within one period as a wrong high time or a wrong repeat length. The bench therefore compares every output sample against a computed waveform for two full periods, on both channels at once. A working copy loaded at the wrong moment shows as a change in pulse shape before the period boundary rather than after it. A broken stop sequencer shows within one clock in abrupt mode, and at the period end in graceful mode. Decode faults show up on the next register readback.

// File: rtl/pwm_ctrl_pkg.sv
// Shared field widths, bit positions and register types of the PWM block.
// Assumes word-addressed registers with three used slots per channel.
package pwm_ctrl_pkg;
    localparam int PS_W     = 6;   // prescale field width
    localparam int CNT_W    = 10;  // period / duty field width
    localparam int SD_BIT   = 6;   // stop-mode bit in control register
    localparam int FULL_BIT = 10;  // full-duty flag in duty register
    localparam int CTL_W    = PS_W + 1;
    localparam int DUTY_W   = CNT_W + 1;

    localparam logic [1:0] SEL_CTL  = 2'd0;
    localparam logic [1:0] SEL_DUTY = 2'd1;
    localparam logic [1:0] SEL_PER  = 2'd2;

    typedef struct packed {
        logic            stop_now;
        logic [PS_W-1:0] presc;
    } ctl_t;

    typedef struct packed {
        logic             full;
        logic [CNT_W-1:0] count;
    } duty_t;
endpackage

// File: rtl/pwm_regs.sv
// Register bank of one PWM channel: control, duty and period registers.
// Assumes the write strobe is already decoded for this channel; sel picks
// the register. Unused bits and the fourth slot read as zero.
module pwm_regs
    import pwm_ctrl_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       sel,
    input  logic [DW-1:0]    wdata,
    output ctl_t             ctl_o,
    output duty_t            duty_o,
    output logic [CNT_W-1:0] per_o,
    output logic [DW-1:0]    rdata_o
);
    ctl_t             ctl_q;
    duty_t            duty_q;
    logic [CNT_W-1:0] per_q;

    // Capture writes into the addressed register; reset clears all.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q  <= '0;
            duty_q <= '0;
            per_q  <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_CTL:  ctl_q  <= ctl_t'(wdata[CTL_W-1:0]);
                SEL_DUTY: duty_q <= duty_t'(wdata[DUTY_W-1:0]);
                SEL_PER:  per_q  <= wdata[CNT_W-1:0];
                default:  ;
            endcase
        end
    end

    // Readback mux with zero fill for unused bits.
    always_comb begin
        rdata_o = '0;
        case (sel)
            SEL_CTL:  rdata_o[CTL_W-1:0]  = ctl_q;
            SEL_DUTY: rdata_o[DUTY_W-1:0] = duty_q;
            SEL_PER:  rdata_o[CNT_W-1:0]  = per_q;
            default:  rdata_o = '0;
        endcase
    end

    assign ctl_o  = ctl_q;
    assign duty_o = duty_q;
    assign per_o  = per_q;

    // R8: a duty write is visible on the register output one clock later
    a_r8_duty_readback: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_DUTY) |=> (duty_o == $past(wdata[DUTY_W-1:0])));

    // R8: a period write is visible on the register output one clock later
    a_r8_period_readback: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_PER) |=> (per_o == $past(wdata[CNT_W-1:0])));
endmodule

// File: rtl/pwm_channel.sv
// One PWM time base: prescaler cascaded with a period counter, duty compare
// and a run/stop sequencer. Timing values are copied from the live
// registers only at start and at each period boundary.
// Assumes ctl/duty/per come straight from the channel's register bank.
module pwm_channel
    import pwm_ctrl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  ctl_t             ctl,
    input  duty_t            duty,
    input  logic [CNT_W-1:0] per,
    output logic             pwm_o
);
    logic             running;
    logic [PS_W-1:0]  act_ps;
    logic [CNT_W-1:0] act_pv;
    duty_t            act_duty;
    logic [PS_W-1:0]  pre_cnt;
    logic [CNT_W-1:0] per_cnt;
    logic             tick;
    logic             wrap;

    assign tick = (pre_cnt == act_ps);
    assign wrap = tick && (per_cnt == act_pv);

    // Sequence start, abrupt stop, graceful stop and counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running  <= 1'b0;
            act_ps   <= '0;
            act_pv   <= '0;
            act_duty <= '0;
            pre_cnt  <= '0;
            per_cnt  <= '0;
        end else if (!running) begin
            if (en) begin
                running  <= 1'b1;
                act_ps   <= ctl.presc;
                act_pv   <= per;
                act_duty <= duty;
                pre_cnt  <= '0;
                per_cnt  <= '0;
            end
        end else if (!en && ctl.stop_now) begin
            running <= 1'b0;
            pre_cnt <= '0;
            per_cnt <= '0;
        end else if (wrap) begin
            pre_cnt <= '0;
            per_cnt <= '0;
            if (en) begin
                act_ps   <= ctl.presc;
                act_pv   <= per;
                act_duty <= duty;
            end else begin
                running <= 1'b0;
            end
        end else if (tick) begin
            pre_cnt <= '0;
            per_cnt <= per_cnt + 1'b1;
        end else begin
            pre_cnt <= pre_cnt + 1'b1;
        end
    end

    // Output level from the working copy; counts above V+1 saturate high.
    always_comb begin
        pwm_o = running && (act_duty.full || (per_cnt < act_duty.count));
    end

    // R5: abrupt stop drops the output on the next clock
    a_r5_abrupt_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && ctl.stop_now) |=> !pwm_o);

    // R1: both counters stay inside their programmed limits
    a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (per_cnt <= act_pv && pre_cnt <= act_ps));

    // R7: the working copy only changes at a period boundary
    a_r7_hold_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !wrap) |=> $stable({act_ps, act_pv, act_duty}));

    // R6: graceful stop keeps running until the boundary
    a_r6_graceful_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !en && !ctl.stop_now && !wrap) |=> running);
endmodule

// File: rtl/pwm_ctrl_top.sv
// PWM controller top: address decode, one register bank and one time base
// per channel, and the readback mux. Assumes NUM_CH is 1 or 2; addresses
// of channels that are not built are ignored and read as zero.
module pwm_ctrl_top
    import pwm_ctrl_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int DW     = 32,
    parameter int AW     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     bus_addr,
    input  logic              bus_we,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic [NUM_CH-1:0] chan_en,
    output logic [NUM_CH-1:0] pwm_out
);
    localparam int CH_BIT = 4;

    logic          ch_idx;
    logic [1:0]    sel;
    logic [DW-1:0] rd_ch [NUM_CH];

    assign ch_idx = bus_addr[CH_BIT];
    assign sel    = bus_addr[3:2];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        ctl_t             ctl_w;
        duty_t            duty_w;
        logic [CNT_W-1:0] per_w;
        logic             wr_c;

        assign wr_c = bus_we && (ch_idx == 1'(c));

        pwm_regs #(.DW(DW)) u_regs (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_c),
            .sel     (sel),
            .wdata   (bus_wdata),
            .ctl_o   (ctl_w),
            .duty_o  (duty_w),
            .per_o   (per_w),
            .rdata_o (rd_ch[c])
        );

        pwm_channel u_chan (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (chan_en[c]),
            .ctl   (ctl_w),
            .duty  (duty_w),
            .per   (per_w),
            .pwm_o (pwm_out[c])
        );
    end

    // Select the addressed channel's readback; absent channels read zero.
    always_comb begin
        bus_rdata = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (ch_idx == 1'(c)) bus_rdata = rd_ch[c];
        end
    end

    // R9: the first clock after a reset edge shows all outputs low
    a_r9_reset_low: assert property (@(posedge clk)
        $fell(rst_n) |=> (pwm_out == '0));
endmodule

// File: tb/test_pwm_ctrl_top.sv
module test_pwm_ctrl_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata, rdata_one;
    logic [1:0]  chan_en = '0;
    logic [0:0]  en_one = '0;
    logic [1:0]  pwm_out;
    logic [0:0]  pwm_one;
    int compared = 0, mismatched = 0;
    bit done = 0;

    always #10 clk = ~clk; // 50 MHz

    pwm_ctrl_top #(.NUM_CH(2)) i_pwm_ctrl_top (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .chan_en(chan_en),
        .pwm_out(pwm_out));

    pwm_ctrl_top #(.NUM_CH(1)) i_pwm_ctrl_top_one (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(rdata_one), .chan_en(en_one),
        .pwm_out(pwm_one));

    function automatic bit exp_out(int i, int ps, int pv, int dc, bit full);
        int ph;
        ph = i % ((ps + 1) * (pv + 1));
        return full || ((ph / (ps + 1)) < dc);
    endfunction

    task automatic chk(string req, longint act, longint exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [4:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [4:0] a, output logic [31:0] d, output logic [31:0] d1);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata; d1 = rdata_one;
    endtask

    task automatic cfg(int ch, bit sd, int ps, int pv, int dc, bit full);
        logic [4:0] b;
        b = (ch == 1) ? 5'h10 : 5'h00;
        wr(b + 5'h00, {25'd0, sd, 6'(ps)});
        wr(b + 5'h04, {21'd0, full, 10'(dc)});
        wr(b + 5'h08, {22'd0, 10'(pv)});
    endtask

    // Enable both channels together and compare every sample for n clocks.
    task automatic run_both(string req, int n,
                            int ps0, int pv0, int dc0, bit f0,
                            int ps1, int pv1, int dc1, bit f1);
        int bad0, bad1;
        bit a0, a1, e0, e1;
        bad0 = 0; bad1 = 0; a0 = 0; a1 = 0; e0 = 0; e1 = 0;
        @(negedge clk);
        chan_en = 2'b11;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_out[0] != exp_out(i, ps0, pv0, dc0, f0) && bad0 == 0) begin
                bad0 = 1; a0 = pwm_out[0]; e0 = exp_out(i, ps0, pv0, dc0, f0);
            end
            if (pwm_out[1] != exp_out(i, ps1, pv1, dc1, f1) && bad1 == 0) begin
                bad1 = 1; a1 = pwm_out[1]; e1 = exp_out(i, ps1, pv1, dc1, f1);
            end
        end
        chk({req, " ch0"}, a0, e0);
        chk({req, " ch1 (R11)"}, a1, e1);
        chan_en = 2'b00;
        repeat (300) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        logic [31:0] r, r1;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9 out low in reset", pwm_out, 0);
        rst_n = 1'b1;
        rd(5'h04, r, r1); chk("R9 duty cleared", r, 0);
        rd(5'h18, r, r1); chk("R9 ch1 period cleared", r, 0);

        // R8 / R4: readback masks and field positions
        wr(5'h00, 32'hFFFF_FFFF); rd(5'h00, r, r1); chk("R8 ctrl mask", r, 32'h7F);
        wr(5'h04, 32'hFFFF_FFFF); rd(5'h04, r, r1); chk("R8 duty mask", r, 32'h7FF);
        wr(5'h08, 32'hFFFF_FFFF); rd(5'h08, r, r1); chk("R8 period mask", r, 32'h3FF);
        rd(5'h0C, r, r1); chk("R4 unused slot zero", r, 0);
        wr(5'h14, 32'h0000_0123); rd(5'h14, r, r1); chk("R4 ch1 duty", r, 32'h123);
        rd(5'h04, r, r1); chk("R4 ch0 untouched by ch1 write", r, 32'h7FF);

        // R10: single-channel build ignores the second channel's window
        chk("R10 one-ch ch0 ctrl", 0, 0);
        rd(5'h00, r, r1); chk("R10 one-ch ctrl readback", r1, 32'h7F);
        wr(5'h10, 32'h0000_0015); rd(5'h10, r, r1);
        chk("R10 one-ch read 0x10 zero", r1, 0);
        chk("R4 two-ch read 0x10", r, 32'h15);
        rd(5'h00, r, r1); chk("R10 one-ch ch0 not disturbed", r1, 32'h7F);

        // R1/R2/R12 directed corners, with R3 full flag on the other channel
        cfg(0, 1'b1, 1, 4, 2, 1'b0); cfg(1, 1'b1, 0, 3, 0, 1'b1);
        run_both("R1 R2 R3 R12 basic", 20, 1, 4, 2, 0, 0, 3, 0, 1);
        cfg(0, 1'b1, 0, 5, 0, 1'b0); cfg(1, 1'b1, 2, 3, 1023, 1'b0);
        run_both("R2 zero and saturated duty", 24, 0, 5, 0, 0, 2, 3, 1023, 0);
        cfg(0, 1'b1, 0, 0, 1, 1'b0); cfg(1, 1'b1, 3, 2, 3, 1'b0);
        run_both("R1 minimal period, duty V+1", 24, 0, 0, 1, 0, 3, 2, 3, 0);

        // Constrained random patterns on both channels
        for (int k = 0; k < 16; k++) begin
            int p0, v0, d0, p1, v1, d1;
            bit f0, f1;
            p0 = $urandom % 4; v0 = $urandom % 13; d0 = $urandom % (v0 + 3);
            p1 = $urandom % 4; v1 = $urandom % 13; d1 = $urandom % (v1 + 3);
            f0 = ($urandom % 8) == 0; f1 = ($urandom % 8) == 0;
            cfg(0, 1'b1, p0, v0, d0, f0); cfg(1, 1'b1, p1, v1, d1, f1);
            run_both("R1 R2 R11 random", 2 * (p0 + 1) * (v0 + 1) + 2 * (p1 + 1) * (v1 + 1),
                     p0, v0, d0, f0, p1, v1, d1, f1);
        end

        // R5: abrupt stop in the middle of a high phase
        cfg(0, 1'b1, 2, 6, 7, 1'b0);
        @(negedge clk); chan_en = 2'b01;
        repeat (4) @(negedge clk);
        chk("R5 high before stop", pwm_out[0], 1);
        chan_en = 2'b00;
        @(negedge clk);
        chk("R5 low one clock after enable drop", pwm_out[0], 0);
        repeat (40) @(negedge clk);

        // R6: graceful stop finishes the period (P=1, V=4 -> 10 clocks, all high)
        cfg(0, 1'b0, 1, 4, 5, 1'b0);
        @(negedge clk); chan_en = 2'b01;
        for (int i = 0; i <= 3; i++) @(negedge clk);
        chan_en = 2'b00;
        begin
            int bad;
            bad = 0;
            for (int i = 4; i <= 9; i++) begin
                @(negedge clk);
                if (pwm_out[0] !== 1'b1) bad++;
            end
            chk("R6 stays high to period end", bad, 0);
            @(negedge clk);
            chk("R6 low after period end", pwm_out[0], 0);
        end
        repeat (20) @(negedge clk);

        // R7: change duty and period mid-period; old shape holds to boundary
        cfg(0, 1'b1, 0, 9, 2, 1'b0);
        @(negedge clk); chan_en = 2'b01;
        @(negedge clk); // index 0
        begin
            int bad_old, bad_new;
            bad_old = 0; bad_new = 0;
            // wr takes two negedges each: indices 1..4 consumed
            wr(5'h04, 32'd5);
            wr(5'h08, 32'd4);
            for (int i = 5; i <= 9; i++) begin
                @(negedge clk);
                if (pwm_out[0] !== 1'b0) bad_old++;
            end
            for (int i = 10; i <= 19; i++) begin
                @(negedge clk);
                if (pwm_out[0] !== 1'b1) bad_new++;
            end
            chk("R7 old values hold until boundary", bad_old, 0);
            chk("R7 new values after boundary", bad_new, 0);
        end
        chan_en = 2'b00;
        repeat (10) @(negedge clk);

        // R9: reset during a run
        cfg(0, 1'b1, 0, 3, 0, 1'b1);
        @(negedge clk); chan_en = 2'b01;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R9 output low under reset", pwm_out, 0);
        rd(5'h00, r, r1); chk("R9 ctrl cleared by reset", r, 0);
        chan_en = 2'b00; rst_n = 1'b1;
        @(negedge clk);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule